// File: doc/BRIEF.md
# Pulse-Count Phrase Trigger

This block is the control front end of a phrase-playback engine. It is driven over two wires. Software holds an active-low strobe down and sends a train of pulses on a second wire. The block counts those pulses. When the strobe is released, the count becomes the phrase number. A non-zero count starts playback of that phrase. A zero count is a stop command. An active-low power-down input puts the block into standby, where both control wires are ignored.

Each phrase has a sample-rate code that comes from a fixed per-phrase lookup. While playback runs, the block divides its clock by the ratio for that code and emits a one-cycle sample tick. Downstream logic uses the phrase index and the start pulse to fetch data, and uses the tick to pace its output samples. All asynchronous inputs are synchronized inside the block.

Top module: `phrase_trigger`

## Requirements
- R1: After reset, `phrase_o` is 0, `busy_o` is 0, and `start_o`, `stop_o` and `tick_o` are all low.
- R2: Rising edges on `pulse_i` advance the count only while `strobe_n` is low. Pulses sent while `strobe_n` is high do not change the phrase selected by the next command.
- R3: The count is cleared on every falling edge of `strobe_n`, so no count carries over from an earlier command.
- R4: When `strobe_n` rises with a non-zero count N, `start_o` is high for exactly one cycle, `phrase_o` becomes N, and `busy_o` becomes 1.
- R5: When `strobe_n` rises with a count of zero, `stop_o` is high for exactly one cycle, `busy_o` becomes 0 and `phrase_o` becomes 0. `start_o` and `stop_o` are never high together.
- R6: The count is five bits wide and wraps. Thirty-two pulses give a count of 0, which is a stop command. Thirty-three pulses select phrase 1.
- R7: Phrase p uses rate code p mod 7. Codes 0 to 6 divide the clock by DIV_UNIT times 16, 12, 10, 8, 6, 5 and 4. With the default DIV_UNIT of 64, this gives 1024, 768, 640, 512, 384, 320 and 256. The first `tick_o` comes that many cycles after the `start_o` cycle, and later ticks follow at the same spacing.
- R8: A start command during playback restarts playback immediately. The new phrase and its rate replace the old ones, and the divider restarts from zero.
- R9: While `pdwn_n` is low, `busy_o` and `phrase_o` are 0, no tick, start or stop is issued, and strobe and pulse activity is ignored. This holds during standby and after `pdwn_n` returns high.
- R10: `tick_o` is high only while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdwn_n | input | 1 | Asynchronous power-down, low for standby |
| strobe_n | input | 1 | Asynchronous command strobe, low while pulses are counted |
| pulse_i | input | 1 | Asynchronous address pulse line |
| phrase_o | output | 5 | Active phrase index, 0 when stopped |
| start_o | output | 1 | One-cycle start request |
| stop_o | output | 1 | One-cycle stop request |
| busy_o | output | 1 | Playback active |
| tick_o | output | 1 | One-cycle sample tick at the phrase rate |

## Verification
On every cycle, the assertions check these properties:
- start and stop are never high together, and each is a single-cycle pulse;
- a start always leaves a non-zero phrase and the busy flag set;
- ticks occur only while busy, and the divider stays inside its limit;
- a restart clears the divider;
- standby clears the playback state.

Only the bench's scenarios can show the end-to-end behaviour:
- the actual pulse counting, and the clearing of the count on each new strobe;
- wrap-around after thirty-two pulses;
- the exact tick spacing for several rate codes, including the first tick after a restart;
- that commands sent during standby leave no trace.

// File: rtl/ptrig_pkg.sv
package ptrig_pkg;

  localparam int unsigned RATE_W    = 3;
  localparam int unsigned RATE_KINDS = 7;

  // Fixed per-phrase rate code: phrase index modulo the number of rates.
  function automatic logic [RATE_W-1:0] phrase_rate(input int unsigned p);
    return RATE_W'(p % RATE_KINDS);
  endfunction

  // Divide multiplier per rate code; actual ratio is this times DIV_UNIT.
  function automatic int unsigned rate_mult(input logic [RATE_W-1:0] code);
    case (code)
      3'd0:    return 16;
      3'd1:    return 12;
      3'd2:    return 10;
      3'd3:    return 8;
      3'd4:    return 6;
      3'd5:    return 5;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/ptrig_sync.sv
module ptrig_sync #(
  parameter int unsigned W       = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);

  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_d;
  logic [W-1:0]             prev_q;

  always_comb begin
    chain_d[0] = async_i;
    for (int s = 1; s < STAGES; s++) begin
      chain_d[s] = chain_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
      prev_q  <= RST_VAL;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_edge
      assign level_o[g] = chain_q[STAGES-1][g];
      assign rise_o[g]  = chain_q[STAGES-1][g] & ~prev_q[g];
      assign fall_o[g]  = ~chain_q[STAGES-1][g] & prev_q[g];
    end
  endgenerate

endmodule

// File: rtl/ptrig_cmd.sv
module ptrig_cmd #(
  parameter int unsigned PHRASE_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic                st_low_i,
  input  logic                st_fall_i,
  input  logic                st_rise_i,
  input  logic                pi_rise_i,
  output logic [PHRASE_W-1:0] phrase_o,
  output logic                start_o,
  output logic                stop_o,
  output logic                busy_o
);

  logic [PHRASE_W-1:0] cnt_q, cnt_d;
  logic [PHRASE_W-1:0] phrase_q, phrase_d;
  logic                start_q, start_d;
  logic                stop_q, stop_d;
  logic                busy_q, busy_d;
  logic                cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  // Pulse counter: cleared on strobe fall and in standby, wraps naturally.
  always_comb begin
    cnt_d = cnt_q;
    if (!en_i) begin
      cnt_d = '0;
    end else if (st_fall_i) begin
      cnt_d = '0;
    end else if (pi_rise_i && st_low_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  // Command decode on strobe release.
  always_comb begin
    phrase_d = phrase_q;
    busy_d   = busy_q;
    start_d  = 1'b0;
    stop_d   = 1'b0;
    if (!en_i) begin
      phrase_d = '0;
      busy_d   = 1'b0;
    end else if (st_rise_i) begin
      if (cnt_zero) begin
        stop_d   = 1'b1;
        phrase_d = '0;
        busy_d   = 1'b0;
      end else begin
        start_d  = 1'b1;
        phrase_d = cnt_q;
        busy_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      phrase_q <= '0;
      start_q  <= 1'b0;
      stop_q   <= 1'b0;
      busy_q   <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      phrase_q <= phrase_d;
      start_q  <= start_d;
      stop_q   <= stop_d;
      busy_q   <= busy_d;
    end
  end

  assign phrase_o = phrase_q;
  assign start_o  = start_q;
  assign stop_o   = stop_q;
  assign busy_o   = busy_q;

  // R5
  start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_q && stop_q));

  // R4
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);

  // R5
  stop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |=> !stop_q);

  // R4
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (busy_q && phrase_q != '0));

  // R9
  standby_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!busy_q && phrase_q == '0 && !start_q && !stop_q));

endmodule

// File: rtl/ptrig_rate.sv
module ptrig_rate #(
  parameter int unsigned PHRASE_W = 5,
  parameter int unsigned DIV_UNIT = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic                busy_i,
  input  logic                start_i,
  input  logic [PHRASE_W-1:0] phrase_i,
  output logic                tick_o
);
  import ptrig_pkg::*;

  localparam int unsigned NUM_PHRASES = 1 << PHRASE_W;
  localparam int unsigned MAX_DIV     = 16 * DIV_UNIT;
  localparam int unsigned CNT_W       = $clog2(MAX_DIV);

  // Per-phrase rate table.
  logic [RATE_W-1:0] rate_tbl [NUM_PHRASES];

  genvar g;
  generate
    for (g = 0; g < NUM_PHRASES; g++) begin : g_tbl
      assign rate_tbl[g] = phrase_rate(g);
    end
  endgenerate

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  lim_q, lim_d;
  logic [RATE_W-1:0] sel_code;
  logic              run;
  logic              wrap;

  assign sel_code = rate_tbl[phrase_i];
  assign run      = en_i && busy_i;
  assign wrap     = (cnt_q == lim_q);

  always_comb begin
    cnt_d = cnt_q;
    lim_d = lim_q;
    if (!run) begin
      cnt_d = '0;
    end else if (start_i) begin
      cnt_d = '0;
      lim_d = CNT_W'(rate_mult(sel_code) * DIV_UNIT - 1);
    end else if (wrap) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= CNT_W'(MAX_DIV - 1);
    end else begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end

  assign tick_o = run && !start_i && wrap;

  // R10
  tick_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> busy_i);

  // R7
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim_q);

  // R8
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && en_i) |=> (cnt_q == '0));

endmodule

// File: rtl/phrase_trigger.sv
module phrase_trigger #(
  parameter int unsigned PHRASE_W    = 5,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DIV_UNIT    = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pdwn_n,
  input  logic                strobe_n,
  input  logic                pulse_i,
  output logic [PHRASE_W-1:0] phrase_o,
  output logic                start_o,
  output logic                stop_o,
  output logic                busy_o,
  output logic                tick_o
);

  localparam int unsigned IN_W  = 3;
  localparam int unsigned B_PI  = 0;
  localparam int unsigned B_ST  = 1;
  localparam int unsigned B_PD  = 2;
  localparam logic [IN_W-1:0] IN_RST = 3'b010;

  logic [IN_W-1:0] lvl, rise, fall;
  logic            en;

  ptrig_sync #(
    .W       (IN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (IN_RST)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({pdwn_n, strobe_n, pulse_i}),
    .level_o (lvl),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  assign en = lvl[B_PD];

  ptrig_cmd #(
    .PHRASE_W (PHRASE_W)
  ) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en),
    .st_low_i  (!lvl[B_ST]),
    .st_fall_i (fall[B_ST]),
    .st_rise_i (rise[B_ST]),
    .pi_rise_i (rise[B_PI]),
    .phrase_o  (phrase_o),
    .start_o   (start_o),
    .stop_o    (stop_o),
    .busy_o    (busy_o)
  );

  ptrig_rate #(
    .PHRASE_W (PHRASE_W),
    .DIV_UNIT (DIV_UNIT)
  ) u_rate (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en),
    .busy_i   (busy_o),
    .start_i  (start_o),
    .phrase_i (phrase_o),
    .tick_o   (tick_o)
  );

endmodule

// File: tb/phrase_trigger_bench.sv
`timescale 1ns/1ps
module phrase_trigger_bench;

  localparam int unsigned UNIT = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pdwn_n = 1'b1;
  logic       strobe_n = 1'b1;
  logic       pulse_i = 1'b0;
  logic [4:0] phrase_o;
  logic       start_o, stop_o, busy_o, tick_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Monitor state
  int cyc = 0;
  int n_start = 0, n_stop = 0, n_tick = 0;
  int start_run = 0, max_start_run = 0, stop_run = 0, max_stop_run = 0;
  int start_cyc = 0, first_tick = 0, last_tick = 0, prev_tick = 0;
  bit first_pend = 0;
  int both_hi = 0, tick_idle = 0;

  always #10 clk = ~clk;

  phrase_trigger #(.DIV_UNIT(UNIT)) u_phrase_trigger (
    .clk(clk), .rst_n(rst_n), .pdwn_n(pdwn_n), .strobe_n(strobe_n),
    .pulse_i(pulse_i), .phrase_o(phrase_o), .start_o(start_o),
    .stop_o(stop_o), .busy_o(busy_o), .tick_o(tick_o)
  );

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (start_o && stop_o) both_hi++;
      if (tick_o && !busy_o) tick_idle++;
      if (start_o) begin
        n_start++; start_run++; start_cyc = cyc; first_pend = 1;
        if (start_run > max_start_run) max_start_run = start_run;
      end else start_run = 0;
      if (stop_o) begin
        n_stop++; stop_run++;
        if (stop_run > max_stop_run) max_stop_run = stop_run;
      end else stop_run = 0;
      if (tick_o) begin
        n_tick++;
        if (first_pend) begin first_tick = cyc; first_pend = 0; end
        prev_tick = last_tick; last_tick = cyc;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      pulse_i = 1'b1; wait_cyc(4);
      pulse_i = 1'b0; wait_cyc(4);
    end
  endtask

  task automatic send_cmd(input int n);
    strobe_n = 1'b0; wait_cyc(6);
    pulses(n);
    strobe_n = 1'b1; wait_cyc(8);
  endtask

  function automatic int ratio_of(input int p);
    int m[7] = '{16, 12, 10, 8, 6, 5, 4};
    return m[p % 7] * UNIT;
  endfunction

  task automatic t_reset();
    check(phrase_o == 0, "R1 phrase", phrase_o, 0);
    check(busy_o == 0, "R1 busy", busy_o, 0);
    check(!start_o && !stop_o && !tick_o, "R1 pulses",
          {start_o, stop_o, tick_o}, 0);
  endtask

  task automatic t_start();
    int s0 = n_start;
    send_cmd(7);
    check(n_start == s0 + 1, "R4 start count", n_start, s0 + 1);
    check(phrase_o == 7, "R4 phrase", phrase_o, 7);
    check(busy_o == 1, "R4 busy", busy_o, 1);
    check(max_start_run == 1, "R4 start width", max_start_run, 1);
  endtask

  task automatic t_clear_stop();
    int s0 = n_start, p0 = n_stop;
    send_cmd(0);
    check(n_start == s0, "R3 no carried count", n_start, s0);
    check(n_stop == p0 + 1, "R5 stop count", n_stop, p0 + 1);
    check(busy_o == 0 && phrase_o == 0, "R5 idle", {busy_o, phrase_o}, 0);
    check(max_stop_run == 1, "R5 stop width", max_stop_run, 1);
    begin
      int t0 = n_tick;
      wait_cyc(80);
      check(n_tick == t0, "R10 no tick idle", n_tick - t0, 0);
    end
  endtask

  task automatic t_ignore_high();
    pulses(5);
    send_cmd(2);
    check(phrase_o == 2, "R2 high pulses ignored", phrase_o, 2);
  endtask

  task automatic t_wrap();
    int s0 = n_start, p0 = n_stop;
    send_cmd(32);
    check(n_stop == p0 + 1 && n_start == s0, "R6 32 pulses stop", n_stop - p0, 1);
    send_cmd(33);
    check(phrase_o == 1, "R6 33 pulses phrase", phrase_o, 1);
  endtask

  task automatic t_rate(input int p);
    int r = ratio_of(p);
    send_cmd(p);
    wait_cyc(3 * r);
    check(phrase_o == p, "R7 phrase", phrase_o, p);
    check(first_tick - start_cyc == r, "R7 first tick", first_tick - start_cyc, r);
    check(last_tick - prev_tick == r, "R7 interval", last_tick - prev_tick, r);
  endtask

  task automatic t_restart();
    int r;
    send_cmd(3);
    wait_cyc(5);
    send_cmd(4);
    r = ratio_of(4);
    wait_cyc(3 * r);
    check(phrase_o == 4, "R8 new phrase", phrase_o, 4);
    check(first_tick - start_cyc == r, "R8 first tick", first_tick - start_cyc, r);
    check(last_tick - prev_tick == r, "R8 interval", last_tick - prev_tick, r);
  endtask

  task automatic t_standby();
    int s0, t0;
    send_cmd(9);
    pdwn_n = 1'b0; wait_cyc(8);
    check(busy_o == 0 && phrase_o == 0, "R9 standby idle", {busy_o, phrase_o}, 0);
    s0 = n_start; t0 = n_tick;
    send_cmd(3);
    send_cmd(0);
    wait_cyc(40);
    check(n_start == s0, "R9 start ignored", n_start, s0);
    check(n_tick == t0, "R9 no ticks", n_tick - t0, 0);
    pdwn_n = 1'b1; wait_cyc(10);
    check(busy_o == 0 && n_start == s0, "R9 after release", busy_o, 0);
    send_cmd(2);
    check(phrase_o == 2 && busy_o, "R9 resume", phrase_o, 2);
  endtask

  initial begin
    wait_cyc(3);
    t_reset();
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset();
    t_start();
    t_clear_stop();
    t_ignore_high();
    t_wrap();
    t_rate(1);
    t_rate(6);
    t_rate(7);
    t_rate(10);
    t_restart();
    t_standby();
    check(both_hi == 0, "R5 start/stop overlap", both_hi, 0);
    check(tick_idle == 0, "R10 tick while idle", tick_idle, 0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule